// File: doc/BRIEF.md
# Tri-Level PWM Command Decoder with Startup Overvoltage Latch

This block turns the two comparator bits taken from a three-level PWM input into a command for a half-bridge gate driver. The command is one of three values: high-side on, low-side on, or high impedance with both switches off. When the input dwells between the two thresholds for a programmable hold-off time, the block treats it as a request for high impedance. A valid level seen later ends that state.

Two gating inputs take precedence over the PWM input. The first is a supply-good flag: until it is set, both switches are held off. The second is an enable: while it is low, the block stays in high impedance.

While the block is in high impedance and the supply is good, a startup protection is armed. If the phase-node overvoltage flag is seen high in that state, the low-side switch is latched on to clamp the output. The first valid PWM transition clears the latch and disables the protection until the next reset.

All results are registered and appear one clock after the inputs are sampled. Analog thresholds are outside this block.

Top module: `gate_cmd_decoder`

## Requirements
- R1: While `uvlo_ok_i` is sampled low, the next command is 2'b00 (both off) and `ls_latch_o` is 0, whatever the other inputs are. An overvoltage flag seen in that cycle sets nothing.
- R2: With `uvlo_ok_i` high and `en_i` low, the next command is 2'b00, whatever the PWM bits are. The only exception is an active overvoltage latch (R7).
- R3: Command encoding is 2'b00 = high impedance / off, 2'b01 = low-side on, 2'b10 = high-side on. The code 2'b11 never appears. With the block enabled, a sample with `above_hi_i`=1 decodes as high-side on and takes priority when both bits are set. A sample with only `below_lo_i`=1 decodes as low-side on. The decoded command appears one clock later.
- R4: If neither comparator bit is set for HOLDOFF_CYC consecutive enabled samples (default 16), the command becomes 2'b00 after the HOLDOFF_CYC-th sample. Until then the last valid level is held.
- R5: A valid sample that breaks the mid-level run restarts the hold-off count from zero.
- R6: While in high impedance with `en_i` and `uvlo_ok_i` high, the first valid sample is a PWM transition. It ends high impedance and selects the decoded level on the next clock.
- R7: The protection is armed when the supply is good, the block is in high impedance (timed, enable-low or startup), and no PWM transition has happened since reset. If `phase_ov_i` is sampled high while armed, `ls_latch_o` becomes 1 and the command becomes 2'b01 on the next clock. Both hold after `phase_ov_i` falls, even with `en_i` low.
- R8: A PWM transition clears the latch. After the first transition, `phase_ov_i` has no effect until reset.
- R9: During and right after reset, the command is 2'b00, `ls_latch_o` is 0, the block is in high impedance, and the protection is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uvlo_ok_i | input | 1 | Supply above lockout threshold |
| en_i | input | 1 | Driver enable |
| above_hi_i | input | 1 | PWM input above the upper threshold |
| below_lo_i | input | 1 | PWM input below the lower threshold |
| phase_ov_i | input | 1 | Phase node above the overvoltage threshold |
| cmd_o | output | 2 | Gate command (00 off, 01 low-side, 10 high-side) |
| ls_latch_o | output | 1 | Low-side latched on by overvoltage protection |

## Verification
Every result is due at the first rising edge after its inputs are sampled: the decoded level, the entry to and exit from high impedance, the lockout and enable gating, and the latch set and clear. The bench therefore drives the inputs just after a falling edge and samples the outputs at the next falling edge. Hold-off cases drive a run of identical mid-level samples. The check is made after HOLDOFF_CYC-1 samples, where the old level must still hold, and again after the HOLDOFF_CYC-th sample, where the command must have dropped to off.

// File: rtl/gate_cmd_pkg.sv
package gate_cmd_pkg;
  typedef enum logic [1:0] {
    CMD_HIZ  = 2'b00,
    CMD_LOW  = 2'b01,
    CMD_HIGH = 2'b10
  } gate_cmd_e;
endpackage

// File: rtl/gcd_level_sense.sv
module gcd_level_sense #(
  parameter bit BOTH_IS_HIGH = 1'b1
) (
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic valid_o,
  output logic high_o
);
  assign valid_o = above_hi_i | below_lo_i;

  generate
    if (BOTH_IS_HIGH) begin : g_hi_prio
      assign high_o = above_hi_i;
    end else begin : g_lo_prio
      assign high_o = above_hi_i & ~below_lo_i;
    end
  endgenerate
endmodule

// File: rtl/gcd_holdoff_timer.sv
module gcd_holdoff_timer #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R5
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/gcd_ov_guard.sv
module gcd_ov_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uvlo_ok_i,
  input  logic hiz_i,
  input  logic ov_i,
  input  logic trans_i,
  output logic latch_o
);
  logic latch_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (trans_i) done_q <= 1'b1;
      if (!uvlo_ok_i || trans_i)        latch_q <= 1'b0;
      else if (hiz_i && !done_q && ov_i) latch_q <= 1'b1;
    end
  end

  assign latch_o = latch_q;

  // R8
  disarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !latch_q);

  // R7
  latch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(hiz_i && ov_i && uvlo_ok_i));

  // R8
  trans_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_i |=> !latch_q);

  // R1
  lockout_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uvlo_ok_i |=> !latch_q);
endmodule

// File: rtl/gcd_mode_ctrl.sv
module gcd_mode_ctrl
  import gate_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uvlo_ok_i,
  input  logic       en_i,
  input  logic       valid_i,
  input  logic       high_i,
  input  logic       expire_i,
  input  logic       latch_i,
  output logic       hiz_o,
  output logic       trans_o,
  output logic [1:0] cmd_o
);
  logic off_q, hiz_q, lvl_q;
  gate_cmd_e cmd;

  assign trans_o = uvlo_ok_i && en_i && valid_i && (hiz_q || (high_i != lvl_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b1;
      hiz_q <= 1'b1;
      lvl_q <= 1'b0;
    end else if (!uvlo_ok_i) begin
      off_q <= 1'b1;
      hiz_q <= 1'b1;
    end else begin
      off_q <= 1'b0;
      if (!en_i) begin
        hiz_q <= 1'b1;
      end else if (valid_i) begin
        hiz_q <= 1'b0;
        lvl_q <= high_i;
      end else if (expire_i) begin
        hiz_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (off_q)       cmd = CMD_HIZ;
    else if (latch_i) cmd = CMD_LOW;
    else if (hiz_q)  cmd = CMD_HIZ;
    else if (lvl_q)  cmd = CMD_HIGH;
    else             cmd = CMD_LOW;
  end

  assign cmd_o = cmd;
  assign hiz_o = hiz_q;

  // R1
  lockout_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uvlo_ok_i |=> cmd_o == CMD_HIZ);

  // R2
  en_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_ok_i && !en_i |=> cmd_o != CMD_HIGH);

  // R3
  code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 2'b11);

  // R4
  hiz_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hiz_q) && $past(uvlo_ok_i && en_i) |-> $past(expire_i));

  // R6
  hiz_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o |=> cmd_o != CMD_HIZ);
endmodule

// File: rtl/gate_cmd_decoder.sv
module gate_cmd_decoder #(
  parameter int unsigned HOLDOFF_CYC  = 16,
  parameter bit          BOTH_IS_HIGH = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uvlo_ok_i,
  input  logic       en_i,
  input  logic       above_hi_i,
  input  logic       below_lo_i,
  input  logic       phase_ov_i,
  output logic [1:0] cmd_o,
  output logic       ls_latch_o
);
  logic valid, high, expire, hiz, trans, latch, run;

  gcd_level_sense #(.BOTH_IS_HIGH(BOTH_IS_HIGH)) u_sense (
    .above_hi_i (above_hi_i),
    .below_lo_i (below_lo_i),
    .valid_o    (valid),
    .high_o     (high)
  );

  // count only mid-level samples taken while active and not already in hiz
  assign run = uvlo_ok_i && en_i && !valid && !hiz;

  gcd_holdoff_timer #(.HOLD(HOLDOFF_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .expire_o (expire)
  );

  gcd_mode_ctrl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uvlo_ok_i (uvlo_ok_i),
    .en_i      (en_i),
    .valid_i   (valid),
    .high_i    (high),
    .expire_i  (expire),
    .latch_i   (latch),
    .hiz_o     (hiz),
    .trans_o   (trans),
    .cmd_o     (cmd_o)
  );

  gcd_ov_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uvlo_ok_i (uvlo_ok_i),
    .hiz_i     (hiz),
    .ov_i      (phase_ov_i),
    .trans_i   (trans),
    .latch_o   (latch)
  );

  assign ls_latch_o = latch;
endmodule

// File: tb/gate_cmd_decoder_bench.sv
module gate_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  typedef struct packed {
    logic       uv;
    logic       en;
    logic       hi;
    logic       lo;
    logic       ov;
    logic [7:0] reps;
    logic [1:0] cmd;
    logic       lat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd2,  2'b00,1'b0, 4'd1}, // R1 lockout beats high input
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 8'd2,  2'b00,1'b0, 4'd1}, // R1 ov ignored in lockout
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd3,  2'b00,1'b0, 4'd9}, // R9 startup hiz held
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 8'd1,  2'b01,1'b1, 4'd7}, // R7 latch sets
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd2,  2'b01,1'b1, 4'd7}, // R7 latch holds
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1,  2'b10,1'b0, 4'd8}, // R8 transition clears
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'b01,1'b0, 4'd3}, // R3 low
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd1,  2'b10,1'b0, 4'd3}, // R3 both set -> high
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd15, 2'b10,1'b0, 4'd4}, // R4 one short of hold-off
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1,  2'b00,1'b0, 4'd4}, // R4 exact hold-off
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 8'd2,  2'b00,1'b0, 4'd8}, // R8 protection disabled
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'b01,1'b0, 4'd6}, // R6 exit hiz
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd10, 2'b01,1'b0, 4'd5}, // R5 partial run
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'b01,1'b0, 4'd5}, // R5 run broken
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd15, 2'b01,1'b0, 4'd5}, // R5 count restarted
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1,  2'b00,1'b0, 4'd5}, // R5 hiz after full run
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'd2,  2'b00,1'b0, 4'd2}, // R2 en low, high input
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd1,  2'b00,1'b0, 4'd2}, // R2 en low, low input
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1,  2'b10,1'b0, 4'd6}, // R6 enable back
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'd1,  2'b00,1'b0, 4'd2}, // R2 en drop from high
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd1,  2'b00,1'b0, 4'd1}, // R1 lockout mid-run
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1,  2'b10,1'b0, 4'd6}  // R6 resume
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, en = 1'b0, hi = 1'b0, lo = 1'b0, ov = 1'b0;
  logic [1:0] cmd;
  logic lat;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_cmd_decoder #(.HOLDOFF_CYC(HOLD)) u_gate_cmd_decoder (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .uvlo_ok_i  (uv),
    .en_i       (en),
    .above_hi_i (hi),
    .below_lo_i (lo),
    .phase_ov_i (ov),
    .cmd_o      (cmd),
    .ls_latch_o (lat)
  );

  task automatic chk(input int req, input logic [1:0] ecmd, input logic elat);
    n_chk++;
    if (cmd !== ecmd || lat !== elat) begin
      n_fail++;
      $display("FAIL R%0d cmd=%b latch=%b expected cmd=%b latch=%b", req, cmd, lat, ecmd, elat);
    end
  endtask

  task automatic drive(input logic u, input logic e, input logic h, input logic l,
                       input logic o, input int n);
    for (int i = 0; i < n; i++) begin
      uv = u; en = e; hi = h; lo = l; ov = o;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    uv = 1'b0; en = 1'b0; hi = 1'b0; lo = 1'b0; ov = 1'b0;
    repeat (3) @(negedge clk);
    chk(9, 2'b00, 1'b0); // R9 during reset
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(9, 2'b00, 1'b0); // R9 right after release

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].uv, VECS[v].en, VECS[v].hi, VECS[v].lo, VECS[v].ov, int'(VECS[v].reps));
      chk(int'(VECS[v].req), VECS[v].cmd, VECS[v].lat);
    end

    // directed: latch with enable low, lockout clear, re-arm, transition, disable
    do_reset();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    chk(7, 2'b01, 1'b1);  // R7 latch overrides en low
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    chk(1, 2'b00, 1'b0);  // R1 lockout clears latch
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    chk(7, 2'b01, 1'b1);  // R7 re-armed, no transition yet
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    chk(7, 2'b01, 1'b1);  // R7 holds after ov falls
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1);
    chk(8, 2'b01, 1'b0);  // R8 transition clears latch
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, HOLD);
    chk(4, 2'b00, 1'b0);  // R4 hiz after full hold-off
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    chk(8, 2'b00, 1'b0);  // R8 no latch after first transition

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule